// File: doc/BRIEF.md
# Default Control Endpoint Status Register

This block holds the control and status byte for the default control endpoint of a USB device controller. Ownership of the byte is split between the CPU and the USB protocol engine. The CPU issues commands by writing ones: "packet loaded", "stall this transaction" and "last data phase". The engine reports what happened on the bus through single-cycle event strobes: a packet arrived, a packet went out, the control transfer ended, or a STALL handshake was sent. Some flags are cleared by separate "serviced" write-one bits. Some command bits clear themselves once the engine has finished the matching action.

The block drives four control pins. The stall request goes to the engine. The data-end indication marks the final data phase. The FIFO flush pulse fires when a control transfer is cut short. The interrupt pulse goes to the CPU. No data flows through the block, so it has no valid/ready stream interface. Every pin is a plain level or a one-cycle strobe. Register state changes on the clock edge that samples a write or an event. Read data is the current register state, with no added latency.

Top module: `ep0_ctl_csr`

## Requirements
- R1: After reset, the read byte is 00h and stall_req, data_end, irq and fifo_flush are all low.
- R2: The read byte layout is as follows. Bit 5 is send-stall, bit 4 is setup-end, bit 3 is data-end, bit 2 is sent-stall, bit 1 is in-ready and bit 0 is out-ready. Bits 7 and 6 always read 0.
- R3: A packet-received event sets out-ready (bit 0). Writing 1 to bit 6 clears out-ready. A CPU write to bit 0 has no effect.
- R4: Writing 1 to bit 1 sets in-ready. A packet-transmitted event clears in-ready and raises irq. A packet-transmitted event while in-ready is 0 raises no irq.
- R5: Writing 1 to bit 5 sets send-stall, and stall_req follows it. Send-stall stays set until a stall-sent event, which clears it.
- R6: A stall-sent event sets sent-stall (bit 2). Any CPU write with bit 2 equal to 0 clears sent-stall. Writing 1 to bit 2 changes nothing.
- R7: A transfer-end event while data-end is 0 sets setup-end (bit 4) and pulses both irq and fifo_flush. Writing 1 to bit 7 clears setup-end. A CPU write to bit 4 has no effect.
- R8: Writing 1 to bit 3 sets data-end, and the data_end pin follows it. A transfer-end event while data-end is 1 clears data-end. In that case setup-end stays 0 and neither irq nor fifo_flush pulses.
- R9: When a hardware event sets out-ready, setup-end or sent-stall in the same cycle that software clears that flag, the flag ends up set.
- R10: irq and fifo_flush are registered single-cycle pulses. They are high during the cycle after the triggering event and low in the next cycle unless another trigger occurs. A packet-received event also raises irq.
- R11: Writing 0 to bits 5, 3 or 1 leaves send-stall, data-end and in-ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the register byte |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register value |
| ev_rx_pkt | input | 1 | Engine strobe: data packet received |
| ev_tx_done | input | 1 | Engine strobe: data packet transmitted |
| ev_xfer_end | input | 1 | Engine strobe: control transfer ended |
| ev_stall_sent | input | 1 | Engine strobe: STALL handshake sent |
| stall_req | output | 1 | Request to answer with STALL |
| data_end | output | 1 | Last data phase indication |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every result appears one clock after its cause. A write or event strobe sampled at a rising edge shows up in cpu_rdata, stall_req and data_end right after that edge. irq and fifo_flush are high for exactly that following cycle. Each stimulus is applied at a falling edge and removed at the next falling edge, and the outputs are sampled at that same falling edge. Pulse widths are confirmed by an idle cycle and a second sample one falling edge later.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int CSR_W   = 8;
  // bit positions in the CPU-visible byte
  localparam int B_SVC_SE  = 7;
  localparam int B_SVC_OR  = 6;
  localparam int B_STALL   = 5;
  localparam int B_SETEND  = 4;
  localparam int B_DATAEND = 3;
  localparam int B_STALLED = 2;
  localparam int B_INRDY   = 1;
  localparam int B_OUTRDY  = 0;
  // stored flags occupy bits [NFLAG-1:0]
  localparam int NFLAG   = 6;
  localparam int NSTROBE = CSR_W - NFLAG;

  typedef struct packed {
    logic rx_pkt;
    logic tx_done;
    logic xfer_end;
    logic stall_sent;
  } ep0_evt_t;
endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  generate
    if (SET_WINS) begin : g_set_dom
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i | (q & ~clr_i);
      end
    end else begin : g_clr_dom
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ~clr_i & (set_i | q);
      end
    end
  endgenerate

  assign q_o = q;

  generate
    if (SET_WINS) begin : g_chk
      assert_set_dominates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    end
  endgenerate
endmodule

// File: rtl/ep0_csr_decode.sv
module ep0_csr_decode
  import ep0_csr_pkg::*;
(
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  ep0_evt_t         evt_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic [NFLAG-1:0] set_o,
  output logic [NFLAG-1:0] clr_o,
  output logic             early_end_o
);
  logic [CSR_W-1:0] wr_ones;
  logic [CSR_W-1:0] wr_zeros;

  always_comb begin
    wr_ones  = wr_i ? wdata_i : '0;
    wr_zeros = wr_i ? ~wdata_i : '0;
    early_end_o = evt_i.xfer_end & ~flags_i[B_DATAEND];

    set_o = '0;
    clr_o = '0;
    // out-ready: engine sets, serviced strobe clears
    set_o[B_OUTRDY]  = evt_i.rx_pkt;
    clr_o[B_OUTRDY]  = wr_ones[B_SVC_OR];
    // in-ready: software sets, transmit completion clears
    set_o[B_INRDY]   = wr_ones[B_INRDY];
    clr_o[B_INRDY]   = evt_i.tx_done;
    // sent-stall: engine sets, software writes zero to clear
    set_o[B_STALLED] = evt_i.stall_sent;
    clr_o[B_STALLED] = wr_zeros[B_STALLED];
    // data-end: software sets, normal end of transfer clears
    set_o[B_DATAEND] = wr_ones[B_DATAEND];
    clr_o[B_DATAEND] = evt_i.xfer_end & flags_i[B_DATAEND];
    // setup-end: premature end sets, serviced strobe clears
    set_o[B_SETEND]  = early_end_o;
    clr_o[B_SETEND]  = wr_ones[B_SVC_SE];
    // send-stall: software sets, handshake completion clears
    set_o[B_STALL]   = wr_ones[B_STALL];
    clr_o[B_STALL]   = evt_i.stall_sent;
  end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic early_end_i,
  input  logic rx_pkt_i,
  input  logic tx_done_i,
  input  logic in_rdy_i,
  output logic irq_o,
  output logic flush_o
);
  logic irq_q;
  logic flush_q;
  logic irq_cause;

  assign irq_cause = early_end_i | rx_pkt_i | (tx_done_i & in_rdy_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      irq_q   <= irq_cause;
      flush_q <= early_end_i;
    end
  end

  assign irq_o   = irq_q;
  assign flush_o = flush_q;

  assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    early_end_i |=> (flush_o && irq_o));
  assert_rx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pkt_i |=> irq_o);
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!early_end_i && !rx_pkt_i && !tx_done_i) |=> (!irq_o && !flush_o));
endmodule

// File: rtl/ep0_ctl_csr.sv
module ep0_ctl_csr
  import ep0_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       ev_rx_pkt,
  input  logic       ev_tx_done,
  input  logic       ev_xfer_end,
  input  logic       ev_stall_sent,
  output logic       stall_req,
  output logic       data_end,
  output logic       fifo_flush,
  output logic       irq
);
  ep0_evt_t         evt;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic             early_end;

  assign evt = '{rx_pkt: ev_rx_pkt, tx_done: ev_tx_done,
                 xfer_end: ev_xfer_end, stall_sent: ev_stall_sent};

  ep0_csr_decode u_dec (
    .wr_i       (cpu_wr),
    .wdata_i    (cpu_wdata),
    .evt_i      (evt),
    .flags_i    (flags),
    .set_o      (set_v),
    .clr_o      (clr_v),
    .early_end_o(early_end)
  );

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      ep0_flag_cell #(.SET_WINS(1'b1)) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_v[i]),
        .clr_i(clr_v[i]),
        .q_o  (flags[i])
      );
    end
  endgenerate

  ep0_irq_gen u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .early_end_i(early_end),
    .rx_pkt_i   (ev_rx_pkt),
    .tx_done_i  (ev_tx_done),
    .in_rdy_i   (flags[B_INRDY]),
    .irq_o      (irq),
    .flush_o    (fifo_flush)
  );

  assign cpu_rdata = {{NSTROBE{1'b0}}, flags};
  assign stall_req = flags[B_STALL];
  assign data_end  = flags[B_DATAEND];

  assert_outrdy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> cpu_rdata[0]);
  assert_outrdy_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdata[0] && !ev_rx_pkt) |=> !cpu_rdata[0]);
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !ev_stall_sent) |=> stall_req);
  assert_stall_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stall_sent && !(cpu_wr && cpu_wdata[5])) |=> !stall_req);
  assert_normal_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_end && data_end && !(cpu_wr && cpu_wdata[3])) |=> (!data_end && !fifo_flush));
  assert_setend_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdata[4] && !ev_xfer_end) |=> !cpu_rdata[4]);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[7:6] == 2'b00);
endmodule

// File: tb/ep0_ctl_csr_test.sv
module ep0_ctl_csr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       ev_rx_pkt = 1'b0;
  logic       ev_tx_done = 1'b0;
  logic       ev_xfer_end = 1'b0;
  logic       ev_stall_sent = 1'b0;
  logic       stall_req, data_end, fifo_flush, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ep0_ctl_csr uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ev_rx_pkt(ev_rx_pkt), .ev_tx_done(ev_tx_done),
    .ev_xfer_end(ev_xfer_end), .ev_stall_sent(ev_stall_sent),
    .stall_req(stall_req), .data_end(data_end), .fifo_flush(fifo_flush), .irq(irq)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // one cycle of stimulus: applied at a falling edge, removed at the next
  task automatic step(input logic wr, input logic [7:0] d, input logic rx,
                      input logic tx, input logic xe, input logic ss);
    @(negedge clk);
    cpu_wr = wr; cpu_wdata = d; ev_rx_pkt = rx; ev_tx_done = tx;
    ev_xfer_end = xe; ev_stall_sent = ss;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = 8'h00; ev_rx_pkt = 1'b0; ev_tx_done = 1'b0;
    ev_xfer_end = 1'b0; ev_stall_sent = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "rdata", cpu_rdata, 8'h00);
    check("R1", "stall_req", stall_req, 0);
    check("R1", "data_end", data_end, 0);
    check("R1", "irq", irq, 0);
    check("R1", "fifo_flush", fifo_flush, 0);
  endtask

  task automatic t_out_ready();
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3", "out-ready set", cpu_rdata, 8'h01);
    check("R10", "irq on rx", irq, 1);
    idle();
    check("R10", "irq single pulse", irq, 0);
    wr(8'h01);
    check("R3", "write bit0 ignored", cpu_rdata, 8'h01);
    wr(8'h40);
    check("R2", "serviced bit reads 0, out-ready cleared", cpu_rdata, 8'h00);
  endtask

  task automatic t_in_ready();
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", "tx with in-ready 0 no irq", irq, 0);
    wr(8'h02);
    check("R4", "in-ready set", cpu_rdata, 8'h02);
    wr(8'h00);
    check("R11", "write 0 keeps in-ready", cpu_rdata, 8'h02);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", "in-ready cleared by tx", cpu_rdata, 8'h00);
    check("R4", "irq on tx", irq, 1);
  endtask

  task automatic t_stall();
    wr(8'h20);
    check("R5", "stall_req", stall_req, 1);
    check("R2", "send-stall bit5", cpu_rdata, 8'h20);
    wr(8'h00);
    check("R11", "write 0 keeps send-stall", stall_req, 1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5", "stall_req cleared", stall_req, 0);
    check("R6", "sent-stall set", cpu_rdata, 8'h04);
    wr(8'h04);
    check("R6", "write 1 keeps sent-stall", cpu_rdata, 8'h04);
    wr(8'h00);
    check("R6", "write 0 clears sent-stall", cpu_rdata, 8'h00);
  endtask

  task automatic t_setup_end();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R7", "setup-end set", cpu_rdata, 8'h10);
    check("R7", "irq", irq, 1);
    check("R7", "fifo_flush", fifo_flush, 1);
    idle();
    check("R10", "flush single pulse", fifo_flush, 0);
    wr(8'h10);
    check("R7", "write bit4 ignored", cpu_rdata, 8'h10);
    wr(8'h80);
    check("R7", "serviced clears setup-end", cpu_rdata, 8'h00);
  endtask

  task automatic t_data_end();
    wr(8'h08);
    check("R8", "data_end pin", data_end, 1);
    check("R8", "data-end bit3", cpu_rdata, 8'h08);
    wr(8'h00);
    check("R11", "write 0 keeps data-end", cpu_rdata, 8'h08);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8", "normal end clears, no setup-end", cpu_rdata, 8'h00);
    check("R8", "no irq", irq, 0);
    check("R8", "no flush", fifo_flush, 0);
  endtask

  task automatic t_collide();
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", "out-ready set wins", cpu_rdata[0], 1);
    step(1'b1, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9", "setup-end set wins", cpu_rdata[4], 1);
    step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9", "sent-stall set wins", cpu_rdata[2], 1);
    wr(8'hC0);
    check("R9", "all cleared", cpu_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_out_ready();
    t_in_ready();
    t_stall();
    t_setup_end();
    t_data_end();
    t_collide();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule